// File: doc/BRIEF.md
# Store Buffer with Write Fence

This block sits between a core's load/store request port and the coherence port of its private cache. A store from the core is written into a small in-order queue and accepted at once, so the core never waits for ownership of the target line. A drain sequencer takes the oldest queued store and sends an ownership request for its address on the coherence port. It then collects one acknowledgement from each peer core. When the last acknowledgement arrives, the sequencer commits the store into the local line as a modified (dirty) line and removes it from the queue. The commit does not write the line back to lower memory.

Loads are answered in the same cycle. The answer comes from the youngest queued store to the same address if there is one. Otherwise it comes from the cache data, when the line is held locally. Ordinary loads may therefore overtake older queued stores. A store flagged as a fence is sequentially consistent: it holds back every later load until the queue has fully drained and every entry has been acknowledged.

Top module: `store_buffer`

## Requirements
- R1: A store offered while `st_ready` is high is accepted in that cycle, and stores can be accepted on back-to-back cycles with no wait for the coherence port.
- R2: A queued store commits (`cm_valid` high) only in the cycle in which the last missing peer acknowledgement bit of `cr_ack` arrives. Bit k of `cr_ack` is the acknowledgement of peer k, and every bit must have been seen since the ownership handshake.
- R3: A commit reports line state 3 (M, dirty) on `cm_state`. Line states are encoded 0=I, 1=S, 2=E, 3=M.
- R4: A load whose line state input is S, E or M completes in the same cycle (`ld_done`) with the cache data, even while older stores are still queued.
- R5: After a fence store is accepted, no load completes (`ld_blocked` high) until the queue is empty. The first load after the fence store's commit completes.
- R6: Queued stores are requested and committed strictly in acceptance order, one ownership request outstanding at a time. A request holds its address until `cr_req_ready`.
- R7: The queue holds 8 entries. When it is full, `st_ready` is low and an offered store is not taken.
- R8: A load to an address present in the queue completes with the data of the youngest queued store to that address, with `ld_fwd` high, whatever the line state.
- R9: A load to a line in state I with no matching queued store does not complete.
- R10: Acknowledgement bits that arrive before the ownership handshake has completed are ignored.
- R11: `sb_empty` is high exactly when no store is queued or awaiting acknowledgement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Queue can accept a store |
| st_addr | input | 16 | Store address |
| st_data | input | 32 | Store data |
| st_fence | input | 1 | Store is sequentially consistent (fence) |
| ld_valid | input | 1 | Core presents a load |
| ld_addr | input | 16 | Load address |
| ld_line_state | input | 2 | Local state of the load's line (0=I,1=S,2=E,3=M) |
| ld_cache_data | input | 32 | Cache data for the load address |
| ld_done | output | 1 | Load completes this cycle |
| ld_data | output | 32 | Load result |
| ld_fwd | output | 1 | Result was forwarded from the queue |
| ld_blocked | output | 1 | Loads held back by a pending fence |
| cr_req_valid | output | 1 | Ownership request valid |
| cr_req_ready | input | 1 | Coherence port takes the request |
| cr_req_addr | output | 16 | Ownership request address |
| cr_ack | input | 3 | Per-peer acknowledgement pulses |
| cm_valid | output | 1 | Commit into the local line this cycle |
| cm_addr | output | 16 | Commit address |
| cm_data | output | 32 | Commit data |
| cm_state | output | 2 | Line state written by the commit |
| sb_empty | output | 1 | Queue empty and nothing outstanding |

## Verification
A commit and a new store can fall in the same cycle, and so can a commit and a load that forwards from the entry being committed. The bench provokes both by offering a store and a load to the committing address together with the final acknowledgement bit. It then judges three things: the committing entry still forwards its data in that cycle, the new store is accepted, and the next ownership request carries the new store's address. The bench also judges a fence store entering behind an ordinary store while a load waits. The load must stay blocked through both commits and complete in the first cycle after the last one.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int SB_ADDR_W = 16;
    localparam int SB_DATA_W = 32;

    typedef enum logic [1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_state_e;

    typedef enum logic [1:0] {
        DR_IDLE = 2'd0,
        DR_REQ  = 2'd1,
        DR_WAIT = 2'd2
    } drain_state_e;

    typedef struct packed {
        logic [SB_ADDR_W-1:0] addr;
        logic [SB_DATA_W-1:0] data;
    } sb_entry_t;

    function automatic logic line_readable(input logic [1:0] st);
        return st != LS_I;
    endfunction

endpackage

// File: rtl/sb_fifo.sv
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  sb_entry_t        push_ent,
    input  logic             pop,
    output sb_entry_t        head,
    output logic             full,
    output logic             empty,
    output logic [CNT_W-1:0] count,
    output logic [PTR_W-1:0] rd_ptr,
    output sb_entry_t        ents [DEPTH]
);

    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    sb_entry_t        mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= bump(wr_ptr_q);
            if (pop)  rd_ptr_q <= bump(rd_ptr_q);
            case ({push, pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[wr_ptr_q] <= push_ent;
    end

    assign head   = mem_q[rd_ptr_q];
    assign full   = (count_q == CNT_W'(DEPTH));
    assign empty  = (count_q == '0);
    assign count  = count_q;
    assign rd_ptr = rd_ptr_q;
    assign ents   = mem_q;

endmodule

// File: rtl/sb_fwd.sv
module sb_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sb_entry_t             ents [DEPTH],
    input  logic [PTR_W-1:0]      rd_ptr,
    input  logic [CNT_W-1:0]      count,
    input  logic [SB_ADDR_W-1:0]  ld_addr,
    output logic                  hit,
    output logic [SB_DATA_W-1:0]  data
);

    logic [PTR_W-1:0] slot;

    // Walk from oldest to youngest; a later match overrides an earlier one.
    always_comb begin
        hit  = 1'b0;
        data = '0;
        slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            slot = PTR_W'((int'(rd_ptr) + i) % DEPTH);
            if ((i < int'(count)) && (ents[slot].addr == ld_addr)) begin
                hit  = 1'b1;
                data = ents[slot].data;
            end
        end
    end

endmodule

// File: rtl/sb_drain.sv
module sb_drain
    import sb_pkg::*;
#(
    parameter int NPEER = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 have_entry,
    input  sb_entry_t            head,
    input  logic                 req_ready,
    input  logic [NPEER-1:0]     ack,
    output logic                 req_valid,
    output logic [SB_ADDR_W-1:0] req_addr,
    output logic                 commit,
    output logic [SB_ADDR_W-1:0] commit_addr,
    output logic [SB_DATA_W-1:0] commit_data
);

    drain_state_e     state_q;
    logic [NPEER-1:0] acks_q;
    logic             all_acked;

    assign all_acked   = &(acks_q | ack);
    assign req_valid   = (state_q == DR_REQ);
    assign req_addr    = head.addr;
    assign commit      = (state_q == DR_WAIT) && all_acked;
    assign commit_addr = head.addr;
    assign commit_data = head.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DR_IDLE;
            acks_q  <= '0;
        end else begin
            unique case (state_q)
                DR_IDLE: if (have_entry) state_q <= DR_REQ;
                DR_REQ: if (req_ready) begin
                    state_q <= DR_WAIT;
                    acks_q  <= '0;
                end
                DR_WAIT: begin
                    acks_q <= acks_q | ack;
                    if (all_acked) state_q <= DR_IDLE;
                end
                default: state_q <= DR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NPEER = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 st_valid,
    output logic                 st_ready,
    input  logic [SB_ADDR_W-1:0] st_addr,
    input  logic [SB_DATA_W-1:0] st_data,
    input  logic                 st_fence,
    input  logic                 ld_valid,
    input  logic [SB_ADDR_W-1:0] ld_addr,
    input  logic [1:0]           ld_line_state,
    input  logic [SB_DATA_W-1:0] ld_cache_data,
    output logic                 ld_done,
    output logic [SB_DATA_W-1:0] ld_data,
    output logic                 ld_fwd,
    output logic                 ld_blocked,
    output logic                 cr_req_valid,
    input  logic                 cr_req_ready,
    output logic [SB_ADDR_W-1:0] cr_req_addr,
    input  logic [NPEER-1:0]     cr_ack,
    output logic                 cm_valid,
    output logic [SB_ADDR_W-1:0] cm_addr,
    output logic [SB_DATA_W-1:0] cm_data,
    output logic [1:0]           cm_state,
    output logic                 sb_empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push, full, empty, fence_q, fwd_hit;
    logic [CNT_W-1:0] count;
    logic [PTR_W-1:0] rd_ptr;
    logic [SB_DATA_W-1:0] fwd_data;
    sb_entry_t        push_ent, head;
    sb_entry_t        ents [DEPTH];

    assign st_ready = !full;
    assign push     = st_valid && st_ready;
    assign push_ent = '{addr: st_addr, data: st_data};

    sb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_ent(push_ent), .pop(cm_valid),
        .head(head), .full(full), .empty(empty), .count(count),
        .rd_ptr(rd_ptr), .ents(ents)
    );

    sb_fwd #(.DEPTH(DEPTH)) u_fwd (
        .ents(ents), .rd_ptr(rd_ptr), .count(count), .ld_addr(ld_addr),
        .hit(fwd_hit), .data(fwd_data)
    );

    sb_drain #(.NPEER(NPEER)) u_drain (
        .clk(clk), .rst(rst), .have_entry(!empty), .head(head),
        .req_ready(cr_req_ready), .ack(cr_ack), .req_valid(cr_req_valid),
        .req_addr(cr_req_addr), .commit(cm_valid), .commit_addr(cm_addr),
        .commit_data(cm_data)
    );

    // Fence flag: raised by a fenced store, dropped once the queue runs dry.
    always_ff @(posedge clk) begin
        if (rst)                   fence_q <= 1'b0;
        else if (push && st_fence) fence_q <= 1'b1;
        else if (empty)            fence_q <= 1'b0;
    end

    assign ld_blocked = fence_q && !empty;
    assign ld_fwd     = fwd_hit;
    assign ld_done    = ld_valid && !ld_blocked &&
                        (fwd_hit || line_readable(ld_line_state));
    assign ld_data    = fwd_hit ? fwd_data : ld_cache_data;
    assign cm_state   = cm_valid ? LS_M : LS_I;
    assign sb_empty   = empty;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 8,
    parameter int NPEER = 3,
    parameter int AW    = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             st_valid,
    input logic             st_ready,
    input logic             st_fence,
    input logic             ld_done,
    input logic             cr_req_valid,
    input logic             cr_req_ready,
    input logic [AW-1:0]    cr_req_addr,
    input logic [NPEER-1:0] cr_ack,
    input logic             cm_valid,
    input logic [AW-1:0]    cm_addr
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] occ_q;
    logic             outst_q;
    logic [NPEER-1:0] seen_q;
    logic [AW-1:0]    granted_addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            occ_q          <= '0;
            outst_q        <= 1'b0;
            seen_q         <= '0;
            granted_addr_q <= '0;
        end else begin
            occ_q <= occ_q + CNT_W'(st_valid && st_ready) - CNT_W'(cm_valid);
            if (cr_req_valid && cr_req_ready) begin
                outst_q        <= 1'b1;
                seen_q         <= '0;
                granted_addr_q <= cr_req_addr;
            end else if (cm_valid) begin
                outst_q <= 1'b0;
            end else if (outst_q) begin
                seen_q <= seen_q | cr_ack;
            end
        end
    end

    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (occ_q == CNT_W'(DEPTH)) |-> !st_ready);                             // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready) |-> (occ_q < CNT_W'(DEPTH)));                 // R7
    AST_COMMIT_ALL_ACKED: assert property (@(posedge clk) disable iff (rst)
        cm_valid |-> (outst_q && ((seen_q | cr_ack) == {NPEER{1'b1}})));     // R2
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
        (cr_req_valid && cr_req_ready) |-> !outst_q);                        // R6
    AST_COMMIT_MATCHES_GRANT: assert property (@(posedge clk) disable iff (rst)
        cm_valid |-> (cm_addr == granted_addr_q));                           // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cr_req_valid && !cr_req_ready) |=> (cr_req_valid && $stable(cr_req_addr))); // R6
    AST_FENCE_STALL: assert property (@(posedge clk) disable iff (rst)
        (st_valid && st_ready && st_fence) |=> !ld_done);                    // R5

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .NPEER(NPEER), .AW(sb_pkg::SB_ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
    .st_fence(st_fence), .ld_done(ld_done), .cr_req_valid(cr_req_valid),
    .cr_req_ready(cr_req_ready), .cr_req_addr(cr_req_addr), .cr_ack(cr_ack),
    .cm_valid(cm_valid), .cm_addr(cm_addr)
);

// File: tb/tb_store_buffer.sv
module tb_store_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_valid = 0, st_fence = 0;
    logic [15:0] st_addr = 0;
    logic [31:0] st_data = 0;
    logic        st_ready;
    logic        ld_valid = 0;
    logic [15:0] ld_addr = 0;
    logic [1:0]  ld_line_state = 0;
    logic [31:0] ld_cache_data = 32'hCAFE_0000;
    logic        ld_done, ld_fwd, ld_blocked;
    logic [31:0] ld_data;
    logic        cr_req_valid, cr_req_ready = 0;
    logic [15:0] cr_req_addr;
    logic [2:0]  cr_ack = 0;
    logic        cm_valid;
    logic [15:0] cm_addr;
    logic [31:0] cm_data;
    logic [1:0]  cm_state;
    logic        sb_empty;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    store_buffer dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .st_fence(st_fence),
        .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_line_state(ld_line_state),
        .ld_cache_data(ld_cache_data), .ld_done(ld_done), .ld_data(ld_data),
        .ld_fwd(ld_fwd), .ld_blocked(ld_blocked), .cr_req_valid(cr_req_valid),
        .cr_req_ready(cr_req_ready), .cr_req_addr(cr_req_addr), .cr_ack(cr_ack),
        .cm_valid(cm_valid), .cm_addr(cm_addr), .cm_data(cm_data),
        .cm_state(cm_state), .sb_empty(sb_empty)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_st(input logic [15:0] a, input logic [31:0] d, input logic f);
        @(negedge clk);
        st_valid = 1; st_addr = a; st_data = d; st_fence = f;
        #1 chk(st_ready, "R1 store accepted without stall", st_ready, 1);
        @(posedge clk); #1;
        st_valid = 0; st_fence = 0;
    endtask

    // Wait for the request, check it, hand it over, then ack peers one by one.
    task automatic serve_one(input logic [15:0] a, input logic [31:0] d);
        int n = 0;
        @(negedge clk); #1;
        while (!cr_req_valid && n < 100) begin @(negedge clk); #1; n++; end
        chk(cr_req_valid && cr_req_addr == a, "R6 in-order ownership request", cr_req_addr, a);
        cr_req_ready = 1;
        @(negedge clk);
        cr_req_ready = 0; cr_ack = 3'b001;
        #1 chk(!cm_valid, "R2 no commit on partial ack", cm_valid, 0);
        @(negedge clk); cr_ack = 3'b100;
        #1 chk(!cm_valid, "R2 no commit on partial ack", cm_valid, 0);
        @(negedge clk); cr_ack = 3'b010;
        #1 chk(cm_valid && cm_addr == a && cm_data == d, "R2 commit on last ack", {cm_addr, cm_data}, {a, d});
        chk(cm_state == 2'd3, "R3 commit marks line M", cm_state, 3);
        @(negedge clk); cr_ack = 0;
    endtask

    task automatic t_reset;
        #1 chk(st_ready && sb_empty && !cr_req_valid && !cm_valid && !ld_blocked,
               "R11 reset state", {st_ready, sb_empty, cr_req_valid, cm_valid, ld_blocked}, 5'b11000);
    endtask

    task automatic t_bypass;
        push_st(16'h0040, 32'h1111_0001, 0);
        push_st(16'h0044, 32'h1111_0002, 0);
        @(negedge clk);
        ld_valid = 1; ld_addr = 16'h0080; ld_line_state = 2'd1; ld_cache_data = 32'hAAAA_0080;
        #1 chk(ld_done && !ld_fwd && ld_data == 32'hAAAA_0080, "R4 S load bypasses queued stores", ld_data, 32'hAAAA_0080);
        chk(!sb_empty, "R11 not empty with queued stores", sb_empty, 0);
        ld_line_state = 2'd3; ld_addr = 16'h0084;
        #1 chk(ld_done, "R4 M load completes", ld_done, 1);
        ld_line_state = 2'd0; ld_addr = 16'h0088;
        #1 chk(!ld_done, "R9 invalid line without forward stalls", ld_done, 0);
        ld_valid = 0;
        // R10: acks while the request is still pending must not count
        cr_ack = 3'b111;
        @(negedge clk); @(negedge clk);
        cr_ack = 0;
        serve_one(16'h0040, 32'h1111_0001);
        serve_one(16'h0044, 32'h1111_0002);
        #1 chk(sb_empty, "R11 empty after drain", sb_empty, 1);
    endtask

    task automatic t_forward;
        push_st(16'h0050, 32'h2222_0001, 0);
        push_st(16'h0054, 32'h2222_0002, 0);
        push_st(16'h0050, 32'h2222_0003, 0);
        @(negedge clk);
        ld_valid = 1; ld_addr = 16'h0050; ld_line_state = 2'd0;
        #1 chk(ld_done && ld_fwd && ld_data == 32'h2222_0003, "R8 youngest store forwarded", ld_data, 32'h2222_0003);
        ld_addr = 16'h0054; ld_line_state = 2'd2;
        #1 chk(ld_fwd && ld_data == 32'h2222_0002, "R8 forward beats cache", ld_data, 32'h2222_0002);
        ld_valid = 0;
        serve_one(16'h0050, 32'h2222_0001);
        serve_one(16'h0054, 32'h2222_0002);
        serve_one(16'h0050, 32'h2222_0003);
    endtask

    task automatic t_overlap;
        int n = 0;
        push_st(16'h0060, 32'h3333_0001, 0);
        @(negedge clk); #1;
        while (!cr_req_valid && n < 100) begin @(negedge clk); #1; n++; end
        cr_req_ready = 1;
        @(negedge clk);
        cr_req_ready = 0; cr_ack = 3'b011;
        @(negedge clk);
        cr_ack = 3'b100;
        st_valid = 1; st_addr = 16'h0064; st_data = 32'h3333_0002;
        ld_valid = 1; ld_addr = 16'h0060; ld_line_state = 2'd0;
        #1 chk(cm_valid && cm_addr == 16'h0060, "R2 commit with concurrent store", cm_addr, 16'h0060);
        chk(ld_done && ld_fwd && ld_data == 32'h3333_0001, "R8 forward from committing entry", ld_data, 32'h3333_0001);
        chk(st_ready, "R1 store accepted during commit", st_ready, 1);
        @(posedge clk); #1;
        st_valid = 0; ld_valid = 0; cr_ack = 0;
        serve_one(16'h0064, 32'h3333_0002);
        #1 chk(sb_empty, "R11 empty after overlap drain", sb_empty, 1);
    endtask

    task automatic t_fence;
        push_st(16'h0010, 32'h4444_0001, 0);
        push_st(16'h0020, 32'h4444_0002, 1);
        @(negedge clk);
        ld_valid = 1; ld_addr = 16'h0300; ld_line_state = 2'd2; ld_cache_data = 32'hBBBB_0300;
        #1 chk(!ld_done && ld_blocked, "R5 load blocked behind fence", ld_done, 0);
        serve_one(16'h0010, 32'h4444_0001);
        #1 chk(!ld_done, "R5 still blocked with fence queued", ld_done, 0);
        serve_one(16'h0020, 32'h4444_0002);
        #1 chk(ld_done && !ld_blocked && ld_data == 32'hBBBB_0300, "R5 load released after drain", ld_data, 32'hBBBB_0300);
        ld_valid = 0;
    endtask

    task automatic t_full;
        for (int i = 0; i < 8; i++) push_st(16'h0100 + 16'(i), 32'h5555_0000 + 32'(i), 0);
        @(negedge clk);
        #1 chk(!st_ready, "R7 full queue drops ready", st_ready, 0);
        st_valid = 1; st_addr = 16'h0FFF; st_data = 32'hDEAD_DEAD;
        @(negedge clk); @(negedge clk);
        st_valid = 0;
        for (int i = 0; i < 8; i++) serve_one(16'h0100 + 16'(i), 32'h5555_0000 + 32'(i));
        #1 chk(sb_empty && !cr_req_valid, "R7 store offered while full not taken", sb_empty, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_bypass();
        t_forward();
        t_overlap();
        t_fence();
        t_full();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule